// File: doc/BRIEF.md
# Hardware Debug Breakpoint Matcher

This block watches a processor's instruction stream and data-access hit strobes and decides when a debug trap must be taken. It holds a small debug register file: four slot address registers, a status register, a control register and two spare registers that only store what is written. Each slot is set by its control field to one of four kinds. An execution slot compares its address with the instruction pointer. A data-write slot or a data-read/write slot takes a hit strobe from an external data-address comparator. An I/O slot never fires.

In every cycle the block works out which slots match. It forms a candidate status word from the current status with the four slot flags cleared. Each matching slot then sets its flag, whether the slot is enabled or not. The candidate is written to the status register only when an enabled slot matched, when the force-update input is high, or when a single-step event arrives. A single-step event also sets the step flag in the status word. A one-cycle trap request follows on the next clock edge whenever an enabled slot matched or a step event occurred.

Top module: `dbg_bp_unit`

## Requirements
- R1: After reset all eight debug registers read as zero and `dbg_req` is low.
- R2: A write with `wr_en` high stores `wr_data` in the register chosen by `wr_sel`, and it can be read back on `rd_data` through `rd_sel` from the next cycle. Index 0 to 3 selects the slot address registers, 6 the status register, 7 the control register, and 4 and 5 the spare registers.
- R3: An execution slot (kind code 2'b00 at control bits 16+4n, 17+4n) matches when `ip_valid` is high and its address register equals `ip`.
- R4: A data-write slot (code 2'b01) or a data-read/write slot (code 2'b11) matches when `wp_hit[n]` is high. `ip` has no effect on such slots, and `wp_hit` has no effect on execution slots.
- R5: An I/O slot (code 2'b10) never matches, whatever `ip` and `wp_hit` carry.
- R6: The candidate status keeps status bits above bit 3 and clears bits 3:0. It then sets bit n for every matching slot n.
- R7: `dbg_req` is high for exactly the cycle after a cycle in which a matching slot had its enable bit (control bit 2n) set, and it is low after cycles with no enabled match and no step event.
- R8: When no enabled slot matches and neither `force_upd` nor `step_evt` is high, the status register keeps its value.
- R9: A `step_evt` cycle commits the candidate status with bit 14 also set, and raises `dbg_req` in the following cycle.
- R10: A new control or address value written through the write port governs matching from the next cycle on.
- R11: A disabled slot that matches sets its status flag only when the status is committed for another reason (force, step or an enabled match). It never raises `dbg_req` on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index for writes |
| wr_data | input | 32 | Write value |
| rd_sel | input | 3 | Register index for reads |
| rd_data | output | 32 | Read value of the selected register |
| ip_valid | input | 1 | Instruction pointer valid this cycle |
| ip | input | 32 | Current instruction pointer |
| wp_hit | input | 4 | Per-slot data-access hit strobes |
| force_upd | input | 1 | Commit the candidate status even without an enabled match |
| step_evt | input | 1 | Single-step event |
| dbg_req | output | 1 | Registered one-cycle debug trap request |

## Verification
The match logic is driven with patterns that separate each decision. Some cycles have a matching slot that is disabled and others one that is enabled, so that status recording can be told apart from trap raising. Other cycles carry a hit on the wrong input for a slot's kind (a strobe on an execution slot, a pointer match on a data slot), so that the kind decode is shown to steer the source. Still others pair an I/O slot with both inputs active. Status words seeded with high bits set show that only the low four bits are cleared. Step events with and without a coincident disabled match show the step flag, the forced commit and the unconditional trap. Directed cases rewrite the address and control registers and show that the next cycle obeys the new values.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

   // Slot kind codes held in the control register
   typedef enum logic [1:0] {
      BK_EXEC = 2'b00,
      BK_DWR  = 2'b01,
      BK_IO   = 2'b10,
      BK_DRW  = 2'b11
   } bp_kind_e;

   localparam int STEP_BIT   = 14;  // single-step flag in status
   localparam int CLR_BITS   = 4;   // low status bits rebuilt each commit
   localparam int KIND_BASE  = 16;  // first kind field in control
   localparam int KIND_PITCH = 4;   // spacing of kind fields
   localparam int STAT_IDX   = 6;
   localparam int CTL_IDX    = 7;

   function automatic int kind_lsb(input int slot);
      return KIND_BASE + KIND_PITCH * slot;
   endfunction

endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
   import dbg_bp_pkg::*;
#(
   parameter int AW  = 32,
   parameter int IDX = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] slot_addr,
   input  logic [AW-1:0] ctl,
   input  logic          ip_valid,
   input  logic [AW-1:0] ip,
   input  logic          wp_hit,
   output logic          hit,
   output logic          enabled
);

   localparam int KL = kind_lsb(IDX);
   localparam int EB = 2 * IDX;

   if (KL + 2 > AW) begin : g_bad_width
      $error("dbg_bp_slot: control word too narrow for slot kind field");
   end

   bp_kind_e kind;
   logic     exec_hit;
   logic     data_hit;

   assign kind     = bp_kind_e'(ctl[KL +: 2]);
   assign enabled  = ctl[EB];
   assign exec_hit = ip_valid && (slot_addr == ip);
   assign data_hit = wp_hit;

   always_comb begin
      unique case (kind)
         BK_EXEC:        hit = exec_hit;
         BK_DWR, BK_DRW: hit = data_hit;
         default:        hit = 1'b0;
      endcase
   end

   // R5: an I/O slot stays silent
   a_r5_io_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[KL +: 2] == 2'b10) |-> !hit);

endmodule

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
   import dbg_bp_pkg::*;
#(
   parameter int AW   = 32,
   parameter int NS   = 4,
   parameter int NREG = 8,
   localparam int SW  = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SW-1:0]          wr_sel,
   input  logic [AW-1:0]          wr_data,
   input  logic [SW-1:0]          rd_sel,
   output logic [AW-1:0]          rd_data,
   input  logic                   stat_commit,
   input  logic [AW-1:0]          stat_next,
   output logic [NS-1:0][AW-1:0]  slot_addr,
   output logic [AW-1:0]          ctl,
   output logic [AW-1:0]          stat
);

   if (NREG <= CTL_IDX) begin : g_bad_nreg
      $error("dbg_bp_regs: register file must reach the control index");
   end

   logic [NREG-1:0][AW-1:0] rf;

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic sel;
      assign sel = wr_en && (wr_sel == SW'(r));
      if (r == STAT_IDX) begin : g_stat
         // hardware commit takes precedence over a software write
         always_ff @(posedge clk) begin
            if (!rst_n)           rf[r] <= '0;
            else if (stat_commit) rf[r] <= stat_next;
            else if (sel)         rf[r] <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)   rf[r] <= '0;
            else if (sel) rf[r] <= wr_data;
         end
      end
   end

   for (genvar s = 0; s < NS; s++) begin : g_slot_out
      assign slot_addr[s] = rf[s];
   end

   assign ctl     = rf[CTL_IDX];
   assign stat    = rf[STAT_IDX];
   assign rd_data = rf[rd_sel];

   // R8: status holds when nothing commits or writes it
   a_r8_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_commit && !(wr_en && wr_sel == SW'(STAT_IDX))) |=> $stable(stat));

   // R2: a plain write lands in the control register
   a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SW'(CTL_IDX)) |=> (ctl == $past(wr_data)));

endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status
   import dbg_bp_pkg::*;
#(
   parameter int AW = 32,
   parameter int NS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] stat_cur,
   input  logic [NS-1:0] hits,
   input  logic [NS-1:0] ens,
   input  logic          force_upd,
   input  logic          step_evt,
   output logic [AW-1:0] stat_next,
   output logic          stat_commit,
   output logic          dbg_req
);

   if (NS < 1 || NS > CLR_BITS) begin : g_bad_ns
      $error("dbg_bp_status: slot count must be 1..4");
   end
   if (AW <= STEP_BIT) begin : g_bad_aw
      $error("dbg_bp_status: status word too narrow for step flag");
   end

   localparam logic [AW-1:0] CLR_MASK  = ~AW'((1 << CLR_BITS) - 1);
   localparam logic [AW-1:0] STEP_MASK = AW'(1) << STEP_BIT;

   logic          en_hit;
   logic [AW-1:0] base;

   assign en_hit = |(hits & ens);
   assign base   = (stat_cur & CLR_MASK) | AW'(hits);

   always_comb begin
      stat_next = base;
      if (step_evt) stat_next = base | STEP_MASK;
   end

   assign stat_commit = en_hit || force_upd || step_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) dbg_req <= 1'b0;
      else        dbg_req <= en_hit || step_evt;
   end

   // R7: an enabled match raises the request next cycle
   a_r7_req_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hits & ens)) |=> dbg_req);

   // R7, R11: no enabled match and no step means no request
   a_r7_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|(hits & ens)) && !step_evt) |=> !dbg_req);

   // R9: a step always traps
   a_r9_step_req: assert property (@(posedge clk) disable iff (!rst_n)
      step_evt |=> dbg_req);

endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
   import dbg_bp_pkg::*;
#(
   parameter int AW   = 32,
   parameter int NS   = 4,
   parameter int NREG = 8,
   localparam int SW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic [SW-1:0] rd_sel,
   output logic [AW-1:0] rd_data,
   input  logic          ip_valid,
   input  logic [AW-1:0] ip,
   input  logic [NS-1:0] wp_hit,
   input  logic          force_upd,
   input  logic          step_evt,
   output logic          dbg_req
);

   if (kind_lsb(NS - 1) + 2 > AW) begin : g_bad_ctl
      $error("dbg_bp_unit: control word cannot hold all kind fields");
   end

   logic [NS-1:0][AW-1:0] slot_addr;
   logic [AW-1:0]         ctl;
   logic [AW-1:0]         stat;
   logic [AW-1:0]         stat_next;
   logic                  stat_commit;
   logic [NS-1:0]         hits;
   logic [NS-1:0]         ens;

   dbg_bp_regs #(.AW(AW), .NS(NS), .NREG(NREG)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .rd_sel      (rd_sel),
      .rd_data     (rd_data),
      .stat_commit (stat_commit),
      .stat_next   (stat_next),
      .slot_addr   (slot_addr),
      .ctl         (ctl),
      .stat        (stat)
   );

   for (genvar s = 0; s < NS; s++) begin : g_slot
      dbg_bp_slot #(.AW(AW), .IDX(s)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .slot_addr (slot_addr[s]),
         .ctl       (ctl),
         .ip_valid  (ip_valid),
         .ip        (ip),
         .wp_hit    (wp_hit[s]),
         .hit       (hits[s]),
         .enabled   (ens[s])
      );
   end

   dbg_bp_status #(.AW(AW), .NS(NS)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .stat_cur    (stat),
      .hits        (hits),
      .ens         (ens),
      .force_upd   (force_upd),
      .step_evt    (step_evt),
      .stat_next   (stat_next),
      .stat_commit (stat_commit),
      .dbg_req     (dbg_req)
   );

   // R9: the step flag shows up in status after a step
   a_r9_step_flag: assert property (@(posedge clk) disable iff (!rst_n)
      step_evt |=> stat[STEP_BIT]);

   // R6: a commit with no match leaves the slot flags clear
   a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_commit && hits == '0) |=> (stat[CLR_BITS-1:0] == '0));

   // R6: a commit keeps the upper status bits except the step flag
   a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_commit && !step_evt) |=> (stat[AW-1:CLR_BITS] == $past(stat[AW-1:CLR_BITS])));

endmodule

// File: tb/dbg_bp_unit_bench.sv
`timescale 1ns/1ps
module dbg_bp_unit_bench;

   localparam int AW = 32;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [AW-1:0] wr_data = '0;
   logic [2:0]    rd_sel = '0;
   logic [AW-1:0] rd_data;
   logic          ip_valid = 1'b0;
   logic [AW-1:0] ip = '0;
   logic [NS-1:0] wp_hit = '0;
   logic          force_upd = 1'b0;
   logic          step_evt = 1'b0;
   logic          dbg_req;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   dbg_bp_unit u_dbg_bp_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .ip_valid(ip_valid), .ip(ip), .wp_hit(wp_hit),
      .force_upd(force_upd), .step_evt(step_evt), .dbg_req(dbg_req)
   );

   typedef struct packed {
      logic [31:0] ctl;
      logic [31:0] pre;
      logic        ipv;
      logic [31:0] ipa;
      logic [3:0]  wp;
      logic        frc;
      logic        stp;
      logic [31:0] exp_st;
      logic        exp_rq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{32'h0000_0055, 32'h0000_A00F, 1'b1, 32'h2000, 4'h0, 1'b0, 1'b0, 32'h0000_A002, 1'b1},
      '{32'h0000_0055, 32'h0000_A00F, 1'b1, 32'h5000, 4'h0, 1'b0, 1'b0, 32'h0000_A00F, 1'b0},
      '{32'h0000_0055, 32'h0000_A00F, 1'b1, 32'h5000, 4'h0, 1'b1, 1'b0, 32'h0000_A000, 1'b0},
      '{32'h0000_0000, 32'h0000_0005, 1'b1, 32'h3000, 4'h0, 1'b0, 1'b0, 32'h0000_0005, 1'b0},
      '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h3000, 4'h0, 1'b1, 1'b0, 32'h0000_0004, 1'b0},
      '{32'h0001_0001, 32'h0000_0000, 1'b0, 32'h0000, 4'h1, 1'b0, 1'b0, 32'h0000_0001, 1'b1},
      '{32'h0300_0010, 32'h0000_0000, 1'b0, 32'h0000, 4'h4, 1'b0, 1'b0, 32'h0000_0004, 1'b1},
      '{32'h0020_0004, 32'h0000_0003, 1'b1, 32'h2000, 4'h2, 1'b0, 1'b0, 32'h0000_0003, 1'b0},
      '{32'h0020_0004, 32'h0000_0003, 1'b1, 32'h2000, 4'h2, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
      '{32'h0000_0055, 32'h0000_0009, 1'b0, 32'h0000, 4'hF, 1'b0, 1'b0, 32'h0000_0009, 1'b0},
      '{32'h0001_0001, 32'h0000_0006, 1'b1, 32'h1000, 4'h0, 1'b0, 1'b0, 32'h0000_0006, 1'b0},
      '{32'h0001_0040, 32'h0000_00F0, 1'b1, 32'h4000, 4'h1, 1'b0, 1'b0, 32'h0000_00F9, 1'b1},
      '{32'h0000_0000, 32'h0000_000F, 1'b0, 32'h0000, 4'h0, 1'b0, 1'b1, 32'h0000_4000, 1'b1},
      '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h1000, 4'h0, 1'b0, 1'b1, 32'h0000_4001, 1'b1},
      '{32'h0031_0005, 32'h0000_0000, 1'b0, 32'h0000, 4'h3, 1'b0, 1'b0, 32'h0000_0003, 1'b1}
   };

   function automatic string tag_of(input int i);
      case (i)
         0:       return "R3";   // enabled execution hit, high bits kept
         1:       return "R8";   // no match, status held
         2:       return "R6";   // forced commit clears flags
         3:       return "R11";  // disabled hit alone, no commit
         4:       return "R11";  // disabled hit recorded under force
         5, 6:    return "R4";   // data-write and data-read/write strobes
         7, 8:    return "R5";   // I/O slot with both inputs active
         9, 10:   return "R4";   // wrong source for the kind
         11:      return "R7";   // enabled and disabled hit together
         12, 13:  return "R9";   // single step
         default: return "R7";   // two enabled data hits
      endcase
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_chk(input logic [2:0] sel, input logic [31:0] exp,
                           input string req);
      rd_sel = sel;
      #1;
      check(rd_data === exp, req, rd_data, exp);
   endtask

   task automatic clear_stim();
      ip_valid = 1'b0; ip = '0; wp_hit = '0; force_upd = 1'b0; step_evt = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(dbg_req === 1'b0, "R1", 32'(dbg_req), 32'h0);
      for (int r = 0; r < 8; r++) read_chk(3'(r), 32'h0, "R1");

      // R2: address setup and readback
      reg_wr(3'd0, 32'h1000);
      reg_wr(3'd1, 32'h2000);
      reg_wr(3'd2, 32'h3000);
      reg_wr(3'd3, 32'h4000);
      read_chk(3'd2, 32'h3000, "R2");
      reg_wr(3'd4, 32'hDEAD_BEEF);
      read_chk(3'd4, 32'hDEAD_BEEF, "R2");

      for (int i = 0; i < NV; i++) begin
         reg_wr(3'd7, TBL[i].ctl);
         reg_wr(3'd6, TBL[i].pre);
         ip_valid  = TBL[i].ipv;
         ip        = TBL[i].ipa;
         wp_hit    = TBL[i].wp;
         force_upd = TBL[i].frc;
         step_evt  = TBL[i].stp;
         @(negedge clk);
         clear_stim();
         read_chk(3'd6, TBL[i].exp_st, tag_of(i));
         check(dbg_req === TBL[i].exp_rq, tag_of(i), 32'(dbg_req), 32'(TBL[i].exp_rq));
         @(negedge clk);
         // R7: the request lasts one cycle
         check(dbg_req === 1'b0, "R7", 32'(dbg_req), 32'h0);
      end

      // R10: new address takes effect next cycle
      reg_wr(3'd7, 32'h0000_0004);
      reg_wr(3'd6, 32'h0);
      reg_wr(3'd1, 32'h0000_2222);
      ip_valid = 1'b1; ip = 32'h2222;
      @(negedge clk);
      clear_stim();
      check(dbg_req === 1'b1, "R10", 32'(dbg_req), 32'h1);
      read_chk(3'd6, 32'h2, "R10");

      // R10: disabling the slot through control stops the request
      reg_wr(3'd7, 32'h0000_0000);
      reg_wr(3'd6, 32'h0);
      ip_valid = 1'b1; ip = 32'h2222;
      @(negedge clk);
      clear_stim();
      check(dbg_req === 1'b0, "R10", 32'(dbg_req), 32'h0);
      read_chk(3'd6, 32'h0, "R10");

      // R2: spare register kept its value through all of the above
      read_chk(3'd4, 32'hDEAD_BEEF, "R2");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule